// File: doc/BRIEF.md
# Tiled Framebuffer Scanout Address Generator

This block turns one frame scan into a stream of memory read requests. A frame starts with a one-cycle start pulse. The block then reads one 16-bit entry from a tile table in memory. That entry gives the base address of a 64 KB tile. The block then issues burst reads that move the tile's pixel data into a linear display buffer. Each burst carries three values: the source address, the byte count, and the byte offset in the display buffer where the data lands. The block does not move any pixel data itself. The memory model, the pixel datapath, colour lookup and display timing are all handled elsewhere.

There are two layouts. In tiled mode, each tile is 512 bytes wide and 128 lines tall. Tiles are placed left to right and then wrap to the next tile row. Tiles that run past the right or bottom edge of the screen are clipped. In linear mode, each tile is copied as one contiguous 64 KB span, split into fixed-size chunks. The copy stops exactly when the whole frame has been covered.

All requests leave on a single valid/ready channel. A flag on that channel separates table reads from pixel bursts. For a table read, the memory side returns the 16-bit entry as a single-cycle pulse on `tbl_valid`. The memory side may hold `req_ready` low for any number of cycles. While it does, the block keeps the request unchanged.

Top module: `scan_tile_walker`

## Requirements
- R1: After reset, `req_valid`, `busy` and `done` are all low.
- R2: A start pulse causes no request and pulses `done` in the next cycle if any of these holds: control bit 0 (enable) is clear, control bits 31..9 are all zero, or either resolution is zero.
- R3: Table read n has `req_table`=1, `req_len`=2 and address {ctrl[31:9], 9'b0} + 2·n. The 16-bit entry returned on `tbl_data` has its first-stored byte in bits 15..8. The entry shifted left by 16 is the tile base.
- R4: Bytes per pixel is 1 << `depth_sel` (8 << `depth_sel` bits). The tile width is 512 >> `depth_sel` pixels.
- R5: In tiled mode (ctrl bit 1 = 0), line y of a tile is read from tile base + 512·y. Its length is clipped pixels × bytes per pixel. Its destination is ((ybase + y)·xres + xbase) × bytes per pixel.
- R6: In tiled mode, tiles are visited left to right, and then top to bottom in steps of 128 lines. Pixels per line are clipped to xres − xbase. Lines per tile are clipped to yres − ybase.
- R7: In linear mode (ctrl bit 1 = 1), chunk k of a tile is read from tile base + k·CHUNK_BYTES. The destination is the running byte offset. After 65536/CHUNK_BYTES chunks, the next table entry is fetched.
- R8: In linear mode, the final chunk is cut so that the total equals xres·yres·bytes per pixel. No zero-length burst is issued, even when the frame size is an exact multiple of the chunk size.
- R9: While `req_valid` is high and `req_ready` is low, the request fields stay unchanged.
- R10: `busy` is high from the cycle after an accepted start until the final burst is accepted. `done` is high for exactly the one cycle after that final acceptance.
- R11: A start pulse while `busy` is high is ignored.
- R12: The control word, depth and resolutions are sampled at start. Later changes to them do not affect the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle frame start pulse |
| frm_ctrl | input | 32 | Frame control: bits 31..9 table base, bit 1 linear, bit 0 enable |
| depth_sel | input | 2 | Colour depth field, 8 << value bits per pixel |
| xres | input | XW | Horizontal resolution in pixels |
| yres | input | XW | Vertical resolution in lines |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory side accepts the request |
| req_table | output | 1 | 1 = tile-table read, 0 = pixel burst |
| req_addr | output | AW | Source byte address |
| req_len | output | LEN_W | Byte count |
| req_dst | output | AW | Destination byte offset in the display buffer (0 for table reads) |
| tbl_valid | input | 1 | Table entry returned |
| tbl_data | input | 16 | Table entry, first-stored byte in bits 15..8 |
| busy | output | 1 | Frame walk in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions assume the memory side follows the table protocol. It returns exactly one `tbl_valid` pulse per accepted table read, and only while the block is waiting for that entry. They also assume that xres·yres·8 fits in AW bits. The bench meets both assumptions by construction. It answers each table read after a short delay, in a separate step from the request handshake. It keeps resolutions below 1024. It applies back-pressure in a rotating pattern of zero to two stalled cycles, so the hold rule is exercised on table reads, tiled lines and linear chunks alike.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int TILE_ROW_BYTES  = 512;
  localparam int TILE_LINES      = 128;
  localparam int TILE_SPAN_BYTES = 65536;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TREQ,
    ST_TWAIT,
    ST_LINE,
    ST_CHUNK
  } walk_st_e;
endpackage

// File: rtl/scan_geom.sv
// Tile geometry: width for the depth, edge clipping, wrap tests, frame size.
module scan_geom #(
  parameter int XW = 12,
  parameter int AW = 32
) (
  input  logic [1:0]    shift,
  input  logic [XW-1:0] xres,
  input  logic [XW-1:0] yres,
  input  logic [XW:0]   xbase,
  input  logic [XW:0]   ybase,
  output logic [9:0]    tile_px,
  output logic [9:0]    pix_clip,
  output logic [7:0]    lines_clip,
  output logic          last_col,
  output logic          last_row,
  output logic [AW-1:0] frame_bytes
);
  logic [XW:0] rem_x, rem_y, tpx_w, tln_w;

  always_comb begin
    tile_px    = 10'(scan_pkg::TILE_ROW_BYTES >> shift);
    tpx_w      = (XW+1)'(tile_px);
    tln_w      = (XW+1)'(scan_pkg::TILE_LINES);
    rem_x      = {1'b0, xres} - xbase;
    rem_y      = {1'b0, yres} - ybase;
    pix_clip   = (rem_x < tpx_w) ? rem_x[9:0] : tile_px;
    lines_clip = (rem_y < tln_w) ? rem_y[7:0] : 8'(scan_pkg::TILE_LINES);
    last_col   = (xbase + tpx_w) >= {1'b0, xres};
    last_row   = (ybase + tln_w) >= {1'b0, yres};
    frame_bytes = (AW'(xres) * AW'(yres)) << shift;
  end
endmodule

// File: rtl/scan_dst.sv
// Destination offset of one tiled line in the linear display buffer.
module scan_dst #(
  parameter int XW = 12,
  parameter int AW = 32
) (
  input  logic [1:0]    shift,
  input  logic [XW-1:0] xres,
  input  logic [XW:0]   xbase,
  input  logic [XW:0]   ybase,
  input  logic [6:0]    line,
  output logic [AW-1:0] dst
);
  logic [AW-1:0] row;

  always_comb begin
    row = AW'(ybase) + AW'(line);
    dst = ((row * AW'(xres)) + AW'(xbase)) << shift;
  end
endmodule

// File: rtl/scan_chunk.sv
// Linear-mode chunk sizing with truncation at the frame end.
module scan_chunk #(
  parameter int AW          = 32,
  parameter int CHUNK_BYTES = 16384,
  parameter int LEN_W       = 15
) (
  input  logic [AW-1:0]    lin_off,
  input  logic [AW-1:0]    frame_bytes,
  output logic [LEN_W-1:0] chunk_len,
  output logic             last_chunk
);
  logic [AW-1:0] left;

  always_comb begin
    left       = frame_bytes - lin_off;
    last_chunk = left <= AW'(CHUNK_BYTES);
    chunk_len  = last_chunk ? LEN_W'(left) : LEN_W'(CHUNK_BYTES);
  end
endmodule

// File: rtl/scan_tile_walker.sv
module scan_tile_walker #(
  parameter int XW          = 12,
  parameter int AW          = 32,
  parameter int CHUNK_BYTES = 16384,
  localparam int CK_LOG     = $clog2(CHUNK_BYTES),
  localparam int LEN_W      = ((CK_LOG > 10) ? CK_LOG : 10) + 1,
  localparam int CPT        = scan_pkg::TILE_SPAN_BYTES / CHUNK_BYTES,
  localparam int CI_W       = (CPT > 1) ? $clog2(CPT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      frm_ctrl,
  input  logic [1:0]       depth_sel,
  input  logic [XW-1:0]    xres,
  input  logic [XW-1:0]    yres,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_table,
  output logic [AW-1:0]    req_addr,
  output logic [LEN_W-1:0] req_len,
  output logic [AW-1:0]    req_dst,
  input  logic             tbl_valid,
  input  logic [15:0]      tbl_data,
  output logic             busy,
  output logic             done
);
  import scan_pkg::*;

  walk_st_e      state;
  logic [AW-1:0] tbl_base, tile_ptr, lin_off;
  logic          lin_q;
  logic [1:0]    shift_q;
  logic [XW-1:0] xres_q, yres_q;
  logic [15:0]   tile_nr;
  logic [XW:0]   xbase, ybase;
  logic [6:0]    line;
  logic [CI_W-1:0] chunk_idx;
  logic          done_q;

  logic [9:0]    tile_px, pix_clip;
  logic [7:0]    lines_clip;
  logic          last_col, last_row, last_chunk;
  logic [AW-1:0] frame_bytes, line_dst, chunk_off;
  logic [LEN_W-1:0] chunk_len;
  logic          bad_cfg, accept;

  scan_geom #(.XW(XW), .AW(AW)) u_geom (
    .shift(shift_q), .xres(xres_q), .yres(yres_q), .xbase(xbase), .ybase(ybase),
    .tile_px(tile_px), .pix_clip(pix_clip), .lines_clip(lines_clip),
    .last_col(last_col), .last_row(last_row), .frame_bytes(frame_bytes)
  );

  scan_dst #(.XW(XW), .AW(AW)) u_dst (
    .shift(shift_q), .xres(xres_q), .xbase(xbase), .ybase(ybase),
    .line(line), .dst(line_dst)
  );

  scan_chunk #(.AW(AW), .CHUNK_BYTES(CHUNK_BYTES), .LEN_W(LEN_W)) u_chunk (
    .lin_off(lin_off), .frame_bytes(frame_bytes),
    .chunk_len(chunk_len), .last_chunk(last_chunk)
  );

  generate
    if (CPT > 1) begin : g_multi_chunk
      assign chunk_off = AW'({chunk_idx, {CK_LOG{1'b0}}});
    end else begin : g_single_chunk
      assign chunk_off = '0;
    end
  endgenerate

  assign bad_cfg = !frm_ctrl[0] || (frm_ctrl[31:9] == '0) || (xres == '0) || (yres == '0);
  assign accept  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      done_q    <= 1'b0;
      tbl_base  <= '0;
      tile_ptr  <= '0;
      lin_off   <= '0;
      lin_q     <= 1'b0;
      shift_q   <= '0;
      xres_q    <= '0;
      yres_q    <= '0;
      tile_nr   <= '0;
      xbase     <= '0;
      ybase     <= '0;
      line      <= '0;
      chunk_idx <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (bad_cfg) begin
              done_q <= 1'b1;
            end else begin
              tbl_base  <= AW'({frm_ctrl[31:9], 9'b0});
              lin_q     <= frm_ctrl[1];
              shift_q   <= depth_sel;
              xres_q    <= xres;
              yres_q    <= yres;
              tile_nr   <= '0;
              xbase     <= '0;
              ybase     <= '0;
              line      <= '0;
              chunk_idx <= '0;
              lin_off   <= '0;
              state     <= ST_TREQ;
            end
          end
        end
        ST_TREQ: begin
          if (accept) state <= ST_TWAIT;
        end
        ST_TWAIT: begin
          if (tbl_valid) begin
            tile_ptr <= AW'({tbl_data, 16'h0000});
            line     <= '0;
            state    <= lin_q ? ST_CHUNK : ST_LINE;
          end
        end
        ST_LINE: begin
          if (accept) begin
            if ({1'b0, line} == lines_clip - 8'd1) begin
              tile_nr <= tile_nr + 16'd1;
              if (last_col) begin
                xbase <= '0;
                ybase <= ybase + (XW+1)'(TILE_LINES);
                if (last_row) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
                end else begin
                  state <= ST_TREQ;
                end
              end else begin
                xbase <= xbase + (XW+1)'(tile_px);
                state <= ST_TREQ;
              end
            end else begin
              line <= line + 7'd1;
            end
          end
        end
        ST_CHUNK: begin
          if (accept) begin
            if (last_chunk) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              lin_off <= lin_off + AW'(CHUNK_BYTES);
              if (chunk_idx == CI_W'(CPT - 1)) begin
                chunk_idx <= '0;
                tile_nr   <= tile_nr + 16'd1;
                state     <= ST_TREQ;
              end else begin
                chunk_idx <= chunk_idx + CI_W'(1);
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_valid = (state == ST_TREQ) || (state == ST_LINE) || (state == ST_CHUNK);
    req_table = (state == ST_TREQ);
    req_addr  = '0;
    req_len   = '0;
    req_dst   = '0;
    case (state)
      ST_TREQ: begin
        req_addr = tbl_base + AW'({tile_nr, 1'b0});
        req_len  = LEN_W'(2);
      end
      ST_LINE: begin
        req_addr = tile_ptr + AW'({line, 9'b0});
        req_len  = LEN_W'(pix_clip) << shift_q;
        req_dst  = line_dst;
      end
      ST_CHUNK: begin
        req_addr = tile_ptr + chunk_off;
        req_len  = chunk_len;
        req_dst  = lin_off;
      end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = done_q;
endmodule

// File: rtl/scan_tile_walker_chk.sv
module scan_tile_walker_chk #(
  parameter int AW          = 32,
  parameter int LEN_W       = 15,
  parameter int CHUNK_BYTES = 16384
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_table,
  input logic [AW-1:0]    req_addr,
  input logic [LEN_W-1:0] req_len,
  input logic [AW-1:0]    req_dst,
  input logic             busy,
  input logic             done
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  // R3
  tbl_req_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_table) |-> (req_len == LEN_W'(2) && !req_addr[0]));

  // R8
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_table) |-> (req_len != '0 && req_len <= LEN_W'(CHUNK_BYTES > 512 ? CHUNK_BYTES : 512)));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_table) && $stable(req_addr)
                                   && $stable(req_len) && $stable(req_dst)));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !req_valid));
endmodule

bind scan_tile_walker scan_tile_walker_chk #(
  .AW(AW), .LEN_W(LEN_W), .CHUNK_BYTES(CHUNK_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_table(req_table), .req_addr(req_addr), .req_len(req_len),
  .req_dst(req_dst), .busy(busy), .done(done)
);

// File: tb/scan_tile_walker_tb.sv
module scan_tile_walker_tb;
  localparam int CHUNK = 16384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] frm_ctrl = '0;
  logic [1:0]  depth_sel = '0;
  logic [11:0] xres = '0, yres = '0;
  logic        req_valid, req_table;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr, req_dst;
  logic [14:0] req_len;
  logic        tbl_valid = 1'b0;
  logic [15:0] tbl_data = '0;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  int stall_seq = 0;

  always #2 clk = ~clk;

  scan_tile_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .frm_ctrl(frm_ctrl),
    .depth_sel(depth_sel), .xres(xres), .yres(yres),
    .req_valid(req_valid), .req_ready(req_ready), .req_table(req_table),
    .req_addr(req_addr), .req_len(req_len), .req_dst(req_dst),
    .tbl_valid(tbl_valid), .tbl_data(tbl_data), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string what, input logic [79:0] act, input logic [79:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp_v);
    end
  endtask

  task automatic kick(input logic [31:0] f, input logic [1:0] s, input int x, input int y);
    frm_ctrl = f; depth_sel = s; xres = 12'(x); yres = 12'(y);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Wait for a request, compare it, stall, hold-check, then accept it.
  task automatic take_req(input bit tbl, input logic [31:0] a, input int l, input logic [31:0] d, input string tag);
    logic [79:0] exp_v, got;
    int stall;
    exp_v = {tbl, a, 15'(l), d};
    while (!req_valid) @(negedge clk);
    got = {req_table, req_addr, req_len, req_dst};
    chk(got == exp_v, tag, got, exp_v);
    stall = stall_seq % 3;
    stall_seq++;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      got = {req_table, req_addr, req_len, req_dst};
      chk(req_valid && got == exp_v, "R9 request held under back-pressure", got, exp_v);
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic give_tbl(input logic [15:0] w, input int dly);
    repeat (dly) @(negedge clk);
    tbl_valid = 1'b1; tbl_data = w;
    @(negedge clk);
    tbl_valid = 1'b0;
  endtask

  task automatic end_chk(input string tag);
    chk(done === 1'b1 && busy === 1'b0, {"R10 done pulse ", tag}, {78'd0, busy, done}, 80'd1);
    @(negedge clk);
    chk(done === 1'b0 && req_valid === 1'b0, {"R10 done single cycle ", tag}, {78'd0, req_valid, done}, 80'd0);
  endtask

  // Tiled model: R3 R4 R5 R6
  task automatic run_tiled(input int x, input int y, input int sel, input logic [31:0] base, input string tag);
    int tw, tile, lines, pix;
    logic [15:0] w;
    logic [31:0] tp;
    tw = 512 >> sel;
    tile = 0;
    for (int yb = 0; yb < y; yb += 128) begin
      for (int xb = 0; xb < x; xb += tw) begin
        take_req(1'b1, base + 32'(2 * tile), 2, 32'd0, {"R3 table read ", tag});
        w = 16'(16'h0100 + tile * 3);
        give_tbl(w, 1 + (tile % 2));
        tp = {w, 16'h0000};
        lines = (y - yb < 128) ? y - yb : 128;
        pix = (x - xb < tw) ? x - xb : tw;
        for (int ln = 0; ln < lines; ln++)
          take_req(1'b0, tp + 32'(512 * ln), pix << sel,
                   32'((((yb + ln) * x) + xb) << sel), {"R5 R6 tiled line ", tag});
        tile++;
      end
    end
    end_chk(tag);
  endtask

  // Linear model: R7 R8
  task automatic run_linear(input int x, input int y, input int sel, input logic [31:0] base, input string tag);
    int total, off, tile, len;
    logic [15:0] w;
    total = (x * y) << sel;
    off = 0;
    tile = 0;
    while (off < total) begin
      take_req(1'b1, base + 32'(2 * tile), 2, 32'd0, {"R3 table read ", tag});
      w = 16'(16'h2000 + tile);
      give_tbl(w, 2);
      for (int k = 0; k < 65536 / CHUNK && off < total; k++) begin
        len = (total - off < CHUNK) ? total - off : CHUNK;
        take_req(1'b0, {w, 16'h0000} + 32'(k * CHUNK), len, 32'(off), {"R7 R8 linear chunk ", tag});
        off += CHUNK;
      end
      tile++;
    end
    end_chk(tag);
  endtask

  task automatic t_reset();
    chk(!req_valid && !busy && !done, "R1 reset state", {77'd0, req_valid, busy, done}, 80'd0);
  endtask

  task automatic t_noop(input logic [31:0] f, input int x, input int y, input string tag);
    kick(f, 2'd0, x, y);
    chk(done === 1'b1 && !req_valid && !busy, {"R2 immediate done ", tag}, {77'd0, req_valid, busy, done}, 80'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!req_valid && !done, {"R2 no request ", tag}, {78'd0, req_valid, done}, 80'd0);
    end
  endtask

  task automatic t_busy_start();
    kick(32'h0000_4201, 2'd1, 520, 64);
    chk(busy === 1'b1, "R10 busy after start", {79'd0, busy}, 80'd1);
    frm_ctrl = 32'h0008_0003; depth_sel = 2'd0; xres = 12'd100; yres = 12'd100;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11 R12: walk must follow the first configuration
    run_tiled(520, 64, 1, 32'h0000_4200, "R11 R12 16bpp restart ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_noop(32'h0000_4200, 64, 64, "enable clear");
    t_noop(32'h0000_0103, 64, 64, "zero base");
    t_noop(32'h0000_4201, 0, 64, "zero xres");
    run_tiled_wrap: begin
      kick(32'h0001_0001, 2'd0, 600, 200);
      run_tiled(600, 200, 0, 32'h0001_0000, "R4 8bpp 600x200");
    end
    kick(32'h0002_3E01, 2'd2, 300, 130);
    run_tiled(300, 130, 2, 32'h0002_3E00, "R4 32bpp 300x130");
    kick(32'h0003_0003, 2'd0, 320, 240);
    run_linear(320, 240, 0, 32'h0003_0000, "8bpp 320x240");
    kick(32'h0003_0203, 2'd1, 320, 100);
    run_linear(320, 100, 1, 32'h0003_0200, "R4 16bpp 320x100");
    kick(32'h0003_0003, 2'd0, 256, 128);
    run_linear(256, 128, 0, 32'h0003_0000, "exact multiple");
    t_busy_start();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule